// File: doc/BRIEF.md
# Multiplier-Free 16-Point Number-Theoretic Transform

This block computes a 16-point forward number-theoretic transform over the prime field of order p = 2^64 − 2^32 + 1. A fresh set of sixteen canonical residues can enter on every clock. Six cycles later the sixteen transform bins leave the block as canonical 64-bit residues. The block is meant to be the butterfly core of a larger memory-based transform engine. Twiddle application between passes, data banking and inverse scaling belong to the surrounding logic.

In this field, 2^12 is a primitive 16th root of unity. Every product x_n·w^(nk) is therefore a multiplication by a power of two. Because 2^192 ≡ 1 (mod p), such a product becomes a left rotation of the input after it is zero-extended to 192 bits. For each output bin, one rotation bank produces sixteen rotated terms. A pipelined adder tree sums them with end-around-carry 192-bit additions, which stay congruent mod p without any intermediate reduction. A final registered fold then brings each 192-bit sum down to a residue below p. The block contains no multipliers.

Top module: `ntt_shift_radix`

## Requirements
- R1: For canonical inputs x_0..x_15 (lane n in in_data bits [64n+63:64n]), out_data lane k (bits [64k+63:64k]) equals the sum over n of x_n·2^((12·n·k) mod 192), reduced mod p = 2^64 − 2^32 + 1.
- R2: Every output lane presented with out_valid high is strictly less than p.
- R3: The result for a set sampled with in_valid high at one rising edge appears, with out_valid high, right after the sixth rising edge counted from that one.
- R4: Sets presented on consecutive clocks, or with idle gaps between them, all come out, in arrival order, with their spacing kept.
- R5: While rst is high, and until a set accepted after reset has crossed the pipeline, out_valid stays low. A set in flight when reset is asserted never emerges.
- R6: An all-zero input set yields an all-zero output set.
- R7: A set with one nonzero lane n of value v yields v·2^((12·n·k) mod 192) mod p on lane k. For n = 0, every lane equals v.
- R8: A set with every lane equal to p − 1 yields p − 16 on lane 0 and zero on all other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input set present this cycle |
| in_data | input | 1024 | Sixteen 64-bit residues, lane n at bits [64n+63:64n] |
| out_valid | output | 1 | Output set present this cycle |
| out_data | output | 1024 | Sixteen 64-bit transform bins, bin k at bits [64k+63:64k] |

## Verification
The properties assume that every input lane is already a canonical residue below p. The canonical-output property depends on this, and so do the zero and impulse checks, which compare lane values directly. The bench reduces every random draw below p before driving it. Its hand-picked lanes (p − 1, small impulse values) are below p by construction. The bench never drives in_data above p − 1 while in_valid is high. Expected bins are computed by a direct quadratic DFT using repeated modular doubling.

// File: rtl/ntt_field_pkg.sv
`timescale 1ns/1ps
package ntt_field_pkg;

  localparam int EW = 64;                          // canonical residue width
  localparam int RW = 192;                         // redundant width, 2^RW == 1 mod p
  localparam logic [EW-1:0] PRIME = 64'hFFFF_FFFF_0000_0001;

  // x * 2^amt modulo (2^RW - 1), which is also congruent mod p
  function automatic logic [RW-1:0] rotl_rw(input logic [RW-1:0] v, input int unsigned amt);
    int unsigned a;
    a = amt % RW;
    if (a == 0) return v;
    return (v << a) | (v >> (RW - a));
  endfunction

  // addition modulo 2^RW - 1: the carry out re-enters at bit 0
  function automatic logic [RW-1:0] eac_add(input logic [RW-1:0] a, input logic [RW-1:0] b);
    logic [RW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[RW-1:0] + {{(RW-1){1'b0}}, s[RW]};
  endfunction

endpackage

// File: rtl/ntt_rot_bank.sv
`timescale 1ns/1ps
module ntt_rot_bank
  import ntt_field_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BIN   = 0
) (
  input  logic [LANES*EW-1:0] x_flat,
  output logic [LANES*RW-1:0] t_flat
);

  localparam int STEP = RW / LANES;   // exponent of the primitive root

  for (genvar n = 0; n < LANES; n++) begin : g_term
    localparam int unsigned AMT = (STEP * n * BIN) % RW;
    assign t_flat[n*RW +: RW] = rotl_rw({{(RW-EW){1'b0}}, x_flat[n*EW +: EW]}, AMT);
  end

endmodule

// File: rtl/ntt_sum_tree.sv
`timescale 1ns/1ps
module ntt_sum_tree
  import ntt_field_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                clk,
  input  logic [LANES*RW-1:0] leaf_flat,
  output logic [RW-1:0]       sum_q
);

  localparam int NODES = 2 * LANES;

  // heap layout: node 1 is the root, leaves sit at LANES..2*LANES-1
  logic [RW-1:0] all_n  [1:NODES-1];
  logic [RW-1:0] node_q [1:LANES-1];

  always_comb begin
    for (int i = 1; i < LANES; i++) all_n[i] = node_q[i];
    for (int j = 0; j < LANES; j++) all_n[LANES+j] = leaf_flat[j*RW +: RW];
  end

  always_ff @(posedge clk) begin
    for (int i = 1; i < LANES; i++) node_q[i] <= eac_add(all_n[2*i], all_n[2*i+1]);
  end

  assign sum_q = node_q[1];

endmodule

// File: rtl/ntt_fold64.sv
`timescale 1ns/1ps
module ntt_fold64
  import ntt_field_pkg::*;
(
  input  logic          clk,
  input  logic [RW-1:0] z,
  output logic [EW-1:0] r_q
);

  logic [95:0] lo, hi;
  logic [97:0] v;
  logic [33:0] c1;
  logic [66:0] w1;
  logic [2:0]  c2;
  logic [65:0] w2;
  logic [EW-1:0] res;

  always_comb begin
    lo = z[95:0];
    hi = z[191:96];
    // 2^96 == -1, and 2^96 + 1 is a multiple of p that keeps the result positive
    v  = {2'b00, lo} + {2'b01, 96'd1} - {2'b00, hi};
    // 2^64 == 2^32 - 1
    c1 = v[97:64];
    w1 = {3'b000, v[63:0]} + {1'b0, c1, 32'd0} - {33'd0, c1};
    c2 = w1[66:64];
    w2 = {2'b00, w1[63:0]} + {31'd0, c2, 32'd0} - {63'd0, c2};
    if (w2 >= {2'b00, PRIME}) res = w2[63:0] - PRIME;
    else                      res = w2[63:0];
  end

  always_ff @(posedge clk) r_q <= res;

endmodule

// File: rtl/ntt_shift_radix.sv
`timescale 1ns/1ps
module ntt_shift_radix
  import ntt_field_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*EW-1:0] in_data,
  output logic                out_valid,
  output logic [LANES*EW-1:0] out_data
);

  localparam int LVLS = $clog2(LANES);
  localparam int LAT  = LVLS + 2;     // input reg + tree levels + fold reg

  logic [LANES*EW-1:0] x_q;
  logic [LAT-1:0]      vld_sr;

  always_ff @(posedge clk) x_q <= in_data;

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LAT-2:0], in_valid};
  end

  assign out_valid = vld_sr[LAT-1];

  for (genvar k = 0; k < LANES; k++) begin : g_bin
    logic [LANES*RW-1:0] terms;
    logic [RW-1:0]       acc;

    ntt_rot_bank #(.LANES(LANES), .BIN(k)) u_rot (
      .x_flat (x_q),
      .t_flat (terms)
    );

    ntt_sum_tree #(.LANES(LANES)) u_sum (
      .clk       (clk),
      .leaf_flat (terms),
      .sum_q     (acc)
    );

    ntt_fold64 u_fold (
      .clk (clk),
      .z   (acc),
      .r_q (out_data[k*EW +: EW])
    );
  end

endmodule

// File: rtl/ntt_shift_radix_chk.sv
`timescale 1ns/1ps
module ntt_shift_radix_chk
  import ntt_field_pkg::*;
#(
  parameter int LANES = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [LANES*EW-1:0] in_data,
  input logic                out_valid,
  input logic [LANES*EW-1:0] out_data
);

  localparam int LAT = $clog2(LANES) + 2;

  logic [LAT-1:0] vh, zh, ih;
  logic [EW-1:0]  val_h [LAT];
  logic in_zero, in_imp, out_zero, out_canon, out_eq;

  always_comb begin
    in_zero = (in_data == '0);
    in_imp  = 1'b1;
    for (int n = 1; n < LANES; n++)
      if (in_data[n*EW +: EW] != '0) in_imp = 1'b0;
    out_zero  = (out_data == '0);
    out_canon = 1'b1;
    out_eq    = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (out_data[k*EW +: EW] >= PRIME)          out_canon = 1'b0;
      if (out_data[k*EW +: EW] != val_h[LAT-1])   out_eq    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vh <= '0; zh <= '0; ih <= '0;
    end else begin
      vh <= {vh[LAT-2:0], in_valid};
      zh <= {zh[LAT-2:0], in_valid & in_zero};
      ih <= {ih[LAT-2:0], in_valid & in_imp};
    end
    val_h[0] <= in_data[EW-1:0];
    for (int i = 1; i < LAT; i++) val_h[i] <= val_h[i-1];
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[LAT-1]);                                     // R3
  AST_CANONICAL_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_canon);                                    // R2
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zh[LAT-1]) |-> out_zero);                      // R6
  AST_DC_IMPULSE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ih[LAT-1]) |-> out_eq);                        // R7

endmodule

bind ntt_shift_radix ntt_shift_radix_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/ntt_shift_radix_test.sv
`timescale 1ns/1ps
module ntt_shift_radix_test;

  localparam int L  = 16;
  localparam int W  = 64;
  localparam int NV = 48;
  localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [L*W-1:0] in_data = '0;
  logic out_valid;
  logic [L*W-1:0] out_data;

  always #2 clk = ~clk;

  ntt_shift_radix #(.LANES(L)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, sent = 0, ridx = 0;
  logic [L*W-1:0] expd [NV];
  int             scyc [NV];
  string          tagv [NV];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] addm(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= {1'b0, P}) t = t - {1'b0, P};
    return t[63:0];
  endfunction

  function automatic logic [63:0] mulp2(input logic [63:0] a, input int e);
    logic [63:0] r;
    r = a;
    for (int i = 0; i < e; i++) r = addm(r, r);
    return r;
  endfunction

  function automatic logic [L*W-1:0] dft(input logic [L*W-1:0] x);
    logic [L*W-1:0] y;
    logic [63:0] acc;
    for (int k = 0; k < L; k++) begin
      acc = '0;
      for (int n = 0; n < L; n++)
        acc = addm(acc, mulp2(x[n*W +: W], ((192 / L) * n * k) % 192));
      y[k*W +: W] = acc;
    end
    return y;
  endfunction

  function automatic logic [63:0] rnd64();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    if (r >= P) r = r - P;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [L*W-1:0] v, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    expd[sent] = dft(v);
    scyc[sent] = cyc;
    tagv[sent] = tag;
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
    end
  endtask

  // output monitor: data per R1/R6/R7/R8 and latency per R3, ordering per R4
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ridx >= sent) begin
        chk(1'b0, "R5 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        logic bad;
        logic [63:0] a, e;
        bad = 1'b0; a = '0; e = '0;
        for (int k = 0; k < L; k++)
          if (!bad && out_data[k*W +: W] != expd[ridx][k*W +: W]) begin
            bad = 1'b1; a = out_data[k*W +: W]; e = expd[ridx][k*W +: W];
          end
        chk(!bad, tagv[ridx], a, e);
        chk(cyc - scyc[ridx] == 6, "R3 latency", 64'(cyc - scyc[ridx]), 64'd6);
        ridx++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [L*W-1:0] v;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5 reset state", 64'(out_valid), 64'd0);
    rst = 1'b0;
    idle(2);
    chk(out_valid == 1'b0, "R5 idle after reset", 64'(out_valid), 64'd0);

    send('0, "R6 zero set");

    // single nonzero lane in each position, back to back
    for (int n = 0; n < L; n++) begin
      v = '0;
      v[n*W +: W] = (n == 0) ? P - 64'd1 : {32'h1234_0000 + 32'(n), 32'hDEAD_BEEF};
      send(v, "R7 impulse");
    end
    idle(3);

    for (int n = 0; n < L; n++) v[n*W +: W] = P - 64'd1;
    send(v, "R8 all p-1");

    for (int i = 0; i < 8; i++) begin
      for (int n = 0; n < L; n++) v[n*W +: W] = rnd64();
      send(v, "R1 random");
    end

    // gapped traffic with irregular spacing
    for (int i = 0; i < 5; i++) begin
      for (int n = 0; n < L; n++) v[n*W +: W] = rnd64();
      send(v, "R4 gapped");
      idle(i % 3);
    end
    idle(12);
    chk(ridx == sent, "R4 all delivered", 64'(ridx), 64'(sent));

    // a set in flight when reset arrives must vanish
    @(negedge clk);
    in_valid = 1'b1;
    for (int n = 0; n < L; n++) in_data[n*W +: W] = rnd64();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 flushed by reset", 64'(out_valid), 64'd0);
    end

    for (int n = 0; n < L; n++) v[n*W +: W] = rnd64();
    send(v, "R1 after reset");
    idle(10);
    chk(ridx == sent, "R4 final drain", 64'(ridx), 64'(sent));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule